// File: doc/BRIEF.md
# Interrupt Source Capture Bank

This block keeps the per-source state of a bank of system interrupt inputs, 64 by default and always a whole number of 32-bit words. Each input passes through a synchronizer. A per-source detection mode then decides what counts as an event: a rising edge, a falling edge, a high level or a low level. In edge mode an event latches a status flag that stays set until software clears it. In level mode the status flag tracks the active level. A per-source enable masks the status, and the masked vector comes out on `irq_pend`. Channel mapping, priority logic or host signalling downstream consumes that vector.

Software reaches the bank through a plain synchronous register port. A write takes effect at the clock edge on which `wr_en` is high. A read is combinational from `rd_addr`. The address is split into a 3-bit region, `addr[5:3]`, and a 3-bit slot, `addr[2:0]`. In the vector regions the slot selects the 32-bit word, so source n sits at bit n mod 32 of slot n/32.

Region 0 is the indexed region. Its slots take a source number in `wr_data` and act on that single source, so software never needs a read-modify-write:

| Slot | Action |
|------|--------|
| 0 | enable set |
| 1 | enable clear |
| 2 | status clear |
| 3 | status set |

The vector regions are:

| Region | Write | Read |
|--------|-------|------|
| 1 | clear enable where a bit is 1 | enables |
| 2 | clear status where a bit is 1 | raw status |
| 3 | polarity word | polarity word |
| 4 | detection-type word | detection-type word |
| 5 | set enable where a bit is 1 | enables |

Top module: `isc_bank`

## Requirements
- R1: After reset every enable, status, polarity and type bit is zero, `irq_pend` is zero and every read returns zero.
- R2: The type bit selects the detection mode: 1 means edge and 0 means level. The polarity bit selects the sense: 0 means rising edge or high level, 1 means falling edge or low level. Source n uses bit n mod 32 of slot n/32 in region 3 (polarity) and region 4 (type). Both registers read back as written.
- R3: In edge mode a transition of the input, in the selected direction, sets the status bit on the third rising clock edge after the input changes. The bit then stays set until software clears it. Changing the polarity alone never creates an event.
- R4: In level mode the status bit equals the active level of the input, with the same three-edge latency. Software set and clear writes have no lasting effect in this mode.
- R5: Writing source number n to address 0x00 sets enable n, and writing it to address 0x01 clears enable n. A number of `NUM_SRC` or more changes nothing.
- R6: In edge mode, writing source number n to address 0x02 clears status n, and writing it to address 0x03 sets status n. A number of `NUM_SRC` or more changes nothing.
- R7: A write to region 1 clears every enable whose data bit is 1, and a write to region 5 sets every enable whose data bit is 1. Both regions read back the enable word, so writing all ones to a region-1 word disables its 32 sources.
- R8: A write to region 2 clears every edge-mode status bit whose data bit is 1. Reading region 2 returns the raw, unmasked status word.
- R9: `irq_pend[n]` is high exactly when status n and enable n are both set.
- R10: When an edge event and a status-clear write hit the same bit on the same clock edge, the bit ends up set.
- R11: Writes to unmapped addresses leave all state unchanged, and reads of them return zero. Unmapped addresses are regions 6 and 7, index slots 4 to 7, and vector slots at or above `NUM_SRC/32`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Asynchronous interrupt inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 32 | Combinational read data |
| irq_pend | output | NUM_SRC | Pending-and-enabled sources |

## Verification
A corrupted status or enable bit reaches `irq_pend` in the same cycle, combinationally, and shows in the region 2 or region 1/5 readback in that cycle too. A wrong detection mode or a misplaced edge compare shows up three clock edges after the offending input transition. It appears either as a status flag that never sets or as one that fails to hold once the input returns. Because the expected state is compared on every clock, a fault that corrupts a single bit is caught within one to three cycles of the stimulus that exposes it. That includes a lost capture-over-clear collision.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 6;

  typedef enum logic [2:0] {
    RG_INDEX    = 3'd0,
    RG_ENA_CLR  = 3'd1,
    RG_STAT_CLR = 3'd2,
    RG_POL      = 3'd3,
    RG_TYPE     = 3'd4,
    RG_ENA_SET  = 3'd5,
    RG_HOLE6    = 3'd6,
    RG_HOLE7    = 3'd7
  } region_e;

  localparam logic [2:0] IX_ENA_SET  = 3'd0;
  localparam logic [2:0] IX_ENA_CLR  = 3'd1;
  localparam logic [2:0] IX_STAT_CLR = 3'd2;
  localparam logic [2:0] IX_STAT_SET = 3'd3;

  function automatic logic [ADDR_W-1:0] reg_addr(region_e rg, logic [2:0] slot);
    return {rg, slot};
  endfunction

  // transition in the chosen direction: falling=0 rising, falling=1 falling
  function automatic logic edge_hit(logic cur, logic prv, logic falling);
    return falling ? (prv & ~cur) : (~prv & cur);
  endfunction

  // active level: low_active=0 high, low_active=1 low
  function automatic logic level_on(logic cur, logic low_active);
    return cur ^ low_active;
  endfunction
endpackage

// File: rtl/isc_sync.sv
module isc_sync #(
  parameter int unsigned N      = 64,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] prev_o
);
  logic [N-1:0] stage_q [STAGES];
  logic [N-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign sync_o = stage_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/isc_detect.sv
module isc_detect import isc_pkg::*; #(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic [NUM_SRC-1:0] sync_i,
  input  logic [NUM_SRC-1:0] prev_i,
  input  logic [NUM_SRC-1:0] pol_i,
  input  logic [NUM_SRC-1:0] typ_i,
  output logic [NUM_SRC-1:0] capture_o,
  output logic [NUM_SRC-1:0] lvl_mode_o,
  output logic [NUM_SRC-1:0] lvl_act_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign capture_o[i]  = typ_i[i] & edge_hit(sync_i[i], prev_i[i], pol_i[i]);
    assign lvl_mode_o[i] = ~typ_i[i];
    assign lvl_act_o[i]  = level_on(sync_i[i], pol_i[i]);
  end
endmodule

// File: rtl/isc_status.sv
module isc_status #(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] capture_i,
  input  logic [NUM_SRC-1:0] lvl_mode_i,
  input  logic [NUM_SRC-1:0] lvl_act_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic [NUM_SRC-1:0] set_i,
  output logic [NUM_SRC-1:0] status_q
);
  logic [NUM_SRC-1:0] edge_keep;
  logic [NUM_SRC-1:0] status_d;

  // capture and set are ORed after the clear mask, so an event beats a clear
  assign edge_keep = capture_i | set_i | (status_q & ~clr_i);
  assign status_d  = (lvl_mode_i & lvl_act_i) | (~lvl_mode_i & edge_keep);

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_q & ~clr_i & ~lvl_mode_i) & ~lvl_mode_i & ~status_q) == '0));

  assert_level_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(lvl_mode_i) & (status_q ^ $past(lvl_act_i))) == '0));

  assert_capture_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((capture_i & clr_i) != '0) |=> (($past(capture_i & clr_i) & ~status_q) == '0));
endmodule

// File: rtl/isc_regs.sv
module isc_regs import isc_pkg::*; #(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [NUM_SRC-1:0] status_i,
  output logic [REG_W-1:0]   rd_data,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] pol_q,
  output logic [NUM_SRC-1:0] typ_q,
  output logic [NUM_SRC-1:0] st_clr_o,
  output logic [NUM_SRC-1:0] st_set_o
);
  localparam int unsigned WORDS = NUM_SRC / REG_W;
  localparam int unsigned IDX_W = $clog2(NUM_SRC);

  region_e            wr_rg, rd_rg;
  logic [2:0]         wr_slot, rd_slot;
  logic               idx_ok;
  logic               wr_unmapped;
  logic [NUM_SRC-1:0] idx_1h;
  logic [NUM_SRC-1:0] en_set, en_clr;
  logic [NUM_SRC-1:0] pol_d, typ_d;

  assign wr_rg   = region_e'(wr_addr[5:3]);
  assign wr_slot = wr_addr[2:0];
  assign rd_rg   = region_e'(rd_addr[5:3]);
  assign rd_slot = rd_addr[2:0];

  assign idx_ok = wr_en && (wr_rg == RG_INDEX) && (wr_data < REG_W'(NUM_SRC));

  always_comb begin
    for (int n = 0; n < NUM_SRC; n++) idx_1h[n] = idx_ok && (wr_data[IDX_W-1:0] == IDX_W'(n));
  end

  assign wr_unmapped = wr_en && ((wr_rg == RG_HOLE6) || (wr_rg == RG_HOLE7) ||
                       ((wr_rg == RG_INDEX) && (wr_slot > IX_STAT_SET)) ||
                       ((wr_rg != RG_INDEX) && (32'(wr_slot) >= WORDS)));

  always_comb begin
    pol_d    = pol_q;
    typ_d    = typ_q;
    en_set   = '0;
    en_clr   = '0;
    st_clr_o = '0;
    st_set_o = '0;
    if (wr_rg == RG_INDEX) begin
      unique case (wr_slot)
        IX_ENA_SET:  en_set   = idx_1h;
        IX_ENA_CLR:  en_clr   = idx_1h;
        IX_STAT_CLR: st_clr_o = idx_1h;
        IX_STAT_SET: st_set_o = idx_1h;
        default: ;
      endcase
    end
    for (int w = 0; w < WORDS; w++) begin
      if (wr_en && (wr_slot == 3'(w))) begin
        unique case (wr_rg)
          RG_ENA_CLR:  en_clr[w*REG_W +: REG_W]   = wr_data;
          RG_ENA_SET:  en_set[w*REG_W +: REG_W]   = wr_data;
          RG_STAT_CLR: st_clr_o[w*REG_W +: REG_W] = wr_data;
          RG_POL:      pol_d[w*REG_W +: REG_W]    = wr_data;
          RG_TYPE:     typ_d[w*REG_W +: REG_W]    = wr_data;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      pol_q <= '0;
      typ_q <= '0;
    end else begin
      en_q  <= (en_q | en_set) & ~en_clr;
      pol_q <= pol_d;
      typ_q <= typ_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (rd_slot == 3'(w)) begin
        unique case (rd_rg)
          RG_ENA_CLR, RG_ENA_SET: rd_data = en_q[w*REG_W +: REG_W];
          RG_STAT_CLR:            rd_data = status_i[w*REG_W +: REG_W];
          RG_POL:                 rd_data = pol_q[w*REG_W +: REG_W];
          RG_TYPE:                rd_data = typ_q[w*REG_W +: REG_W];
          default: ;
        endcase
      end
    end
  end

  assert_idx_ena_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == reg_addr(RG_INDEX, IX_ENA_SET) && wr_data < REG_W'(NUM_SRC))
    |=> en_q[$past(wr_data[IDX_W-1:0])]);

  assert_idx_ena_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == reg_addr(RG_INDEX, IX_ENA_CLR) && wr_data < REG_W'(NUM_SRC))
    |=> !en_q[$past(wr_data[IDX_W-1:0])]);

  assert_vec_ena_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == reg_addr(RG_ENA_CLR, 3'd0) && wr_data == '1)
    |=> (en_q[REG_W-1:0] == '0));

  assert_unmapped_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmapped |=> ($stable(en_q) && $stable(pol_q) && $stable(typ_q)));
endmodule

// File: rtl/isc_bank.sv
module isc_bank import isc_pkg::*; #(
  parameter int unsigned NUM_SRC     = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               wr_en,
  input  logic [5:0]         wr_addr,
  input  logic [31:0]        wr_data,
  input  logic [5:0]         rd_addr,
  output logic [31:0]        rd_data,
  output logic [NUM_SRC-1:0] irq_pend
);
  logic [NUM_SRC-1:0] sync_v, prev_v;
  logic [NUM_SRC-1:0] en_v, pol_v, typ_v;
  logic [NUM_SRC-1:0] capture_v, lvl_mode_v, lvl_act_v;
  logic [NUM_SRC-1:0] clr_v, set_v, status_v;

  isc_sync #(.N(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(irq_in), .sync_o(sync_v), .prev_o(prev_v)
  );

  isc_detect #(.NUM_SRC(NUM_SRC)) u_detect (
    .sync_i(sync_v), .prev_i(prev_v), .pol_i(pol_v), .typ_i(typ_v),
    .capture_o(capture_v), .lvl_mode_o(lvl_mode_v), .lvl_act_o(lvl_act_v)
  );

  isc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .status_i(status_v), .rd_data(rd_data),
    .en_q(en_v), .pol_q(pol_v), .typ_q(typ_v), .st_clr_o(clr_v), .st_set_o(set_v)
  );

  isc_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk(clk), .rst_n(rst_n), .capture_i(capture_v), .lvl_mode_i(lvl_mode_v),
    .lvl_act_i(lvl_act_v), .clr_i(clr_v), .set_i(set_v), .status_q(status_v)
  );

  assign irq_pend = status_v & en_v;

  // status cannot change on an edge where both the event source and software were quiet
  assert_edge_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (typ_v == '1 && capture_v == '0 && clr_v == '0 && set_v == '0 && !wr_en) |=> $stable(status_v));
endmodule

// File: tb/sim_isc_bank.sv
module sim_isc_bank;
  localparam int N = 64;
  localparam int W = N / 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic          wr_en = 1'b0;
  logic [5:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [5:0]    rd_addr = '0;
  logic [31:0]   rd_data;
  logic [N-1:0]  irq_pend;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_tag = "R1";
  bit done = 1'b0;

  always #5 clk = ~clk;

  isc_bank u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_pend(irq_pend)
  );

  // behavioural reference state
  bit m_en [N];
  bit m_st [N];
  bit m_pol[N];
  bit m_typ[N];
  logic [N-1:0] hist[$];

  function automatic logic [31:0] m_read(logic [5:0] a);
    int rg = int'(a[5:3]);
    int sl = int'(a[2:0]);
    logic [31:0] r = '0;
    if (sl >= W) return '0;
    for (int b = 0; b < 32; b++) begin
      int n = sl * 32 + b;
      case (rg)
        1, 5: r[b] = m_en[n];
        2:    r[b] = m_st[n];
        3:    r[b] = m_pol[n];
        4:    r[b] = m_typ[n];
        default: r[b] = 1'b0;
      endcase
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < N; n++) begin
        m_en[n] = 0; m_st[n] = 0; m_pol[n] = 0; m_typ[n] = 0;
      end
      hist.delete();
    end else begin
      logic [N-1:0] cur, prv;
      int rg, sl;
      hist.push_front(irq_in);
      cur = (hist.size() > 2) ? hist[2] : '0;
      prv = (hist.size() > 3) ? hist[3] : '0;
      if (hist.size() > 4) void'(hist.pop_back());
      rg = int'(wr_addr[5:3]);
      sl = int'(wr_addr[2:0]);
      for (int n = 0; n < N; n++) begin
        bit idx, vec, clr, set, hit;
        idx = wr_en && rg == 0 && wr_data == 32'(n);
        vec = wr_en && sl == n / 32 && wr_data[n % 32];
        clr = (idx && sl == 2) || (vec && rg == 2);
        set = idx && sl == 3;
        if (m_typ[n]) begin
          if (m_pol[n]) hit = prv[n] && !cur[n];
          else          hit = !prv[n] && cur[n];
          if (clr) m_st[n] = 0;
          if (hit || set) m_st[n] = 1;
        end else begin
          m_st[n] = cur[n] != m_pol[n];
        end
        if ((idx && sl == 0) || (vec && rg == 5)) m_en[n] = 1;
        if ((idx && sl == 1) || (vec && rg == 1)) m_en[n] = 0;
        if (wr_en && rg == 3 && sl == n / 32) m_pol[n] = wr_data[n % 32];
        if (wr_en && rg == 4 && sl == n / 32) m_typ[n] = wr_data[n % 32];
      end
    end
  end

  // compare every clock, 3 ns after the rising edge
  always @(posedge clk) begin
    logic [N-1:0] exp_p;
    logic [31:0]  exp_r;
    #3;
    for (int n = 0; n < N; n++) exp_p[n] = m_st[n] && m_en[n];
    exp_r = m_read(rd_addr);
    n_cmp++;
    if (irq_pend !== exp_p) begin
      n_bad++;
      $display("FAIL %s/R9 pending: actual %h expected %h at %0t", cur_tag, irq_pend, exp_p, $time);
    end
    n_cmp++;
    if (rd_data !== exp_r) begin
      n_bad++;
      $display("FAIL %s read addr %h: actual %h expected %h at %0t", cur_tag, rd_addr, rd_data, exp_r, $time);
    end
  end

  // read address sweeps every register continuously
  always @(negedge clk) rd_addr <= rd_addr + 6'd1;

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    cur_tag = "R1";
    idle(5);
    rst_n = 1'b1;
    idle(70);

    cur_tag = "R2";
    wr(6'o30, 32'hA5A5_0F0F);
    wr(6'o41, 32'h1234_5678);
    idle(64);
    wr(6'o30, 32'h0);
    wr(6'o41, 32'h0);

    cur_tag = "R3";
    wr(6'o40, 32'hFFFF_FFFF);
    wr(6'o50, 32'hFFFF_FFFF);
    wr(6'o51, 32'hFFFF_FFFF);
    irq_in[3] = 1'b1; idle(6);
    irq_in[3] = 1'b0; idle(6);
    wr(6'o30, 32'h0000_0010);
    irq_in[4] = 1'b1; idle(6);
    irq_in[4] = 1'b0; idle(6);

    cur_tag = "R4";
    irq_in[40] = 1'b1; idle(6);
    wr(6'o02, 32'd40); idle(4);
    irq_in[40] = 1'b0; idle(6);
    wr(6'o31, 32'h0000_0200);
    idle(6);

    cur_tag = "R5";
    wr(6'o01, 32'd3); idle(3);
    wr(6'o00, 32'd3); idle(3);
    wr(6'o01, 32'd64); idle(2);
    wr(6'o01, 32'd100); idle(2);
    wr(6'o01, 32'd63); idle(3);

    cur_tag = "R6";
    wr(6'o02, 32'd3); idle(3);
    wr(6'o03, 32'd7); idle(3);
    wr(6'o03, 32'd40); idle(3);
    wr(6'o02, 32'd70); idle(3);

    cur_tag = "R7";
    wr(6'o10, 32'hFFFF_FFFF); idle(3);
    wr(6'o50, 32'h0000_0088); idle(3);
    wr(6'o51, 32'hF0F0_0000); idle(3);

    cur_tag = "R8";
    wr(6'o03, 32'd12); wr(6'o03, 32'd13);
    wr(6'o20, 32'hFFFF_FFFF); idle(8);

    cur_tag = "R10";
    wr(6'o50, 32'h0000_0020);
    irq_in[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(6'o02, 32'd5);
    idle(8);

    cur_tag = "R11";
    wr(6'o70, 32'hFFFF_FFFF);
    wr(6'o04, 32'd2);
    wr(6'o12, 32'hFFFF_FFFF);
    wr(6'o33, 32'hFFFF_FFFF);
    idle(70);

    cur_tag = "R9";
    for (int c = 0; c < 4000; c++) begin
      int op = int'($urandom_range(0, 9));
      if ($urandom_range(0, 3) == 0) irq_in[$urandom_range(0, N - 1)] ^= 1'b1;
      if (op < 3) begin
        logic [5:0] a;
        a = {3'($urandom_range(0, 7)), 3'($urandom_range(0, 7))};
        if (a[5:3] == 3'd0) wr(a, 32'($urandom_range(0, 70)));
        else                wr(a, $urandom());
      end else begin
        @(negedge clk);
      end
    end
    idle(5);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule